// File: doc/BRIEF.md
# Word Atomic Memory Operation Unit

This unit carries out the 32-bit atomic instruction group for an integer core. The core hands it an already decoded 5-bit function code, a byte address taken from the first source register, the value of the second source register and the destination register index. The unit then drives a single-port synchronous memory. It reads the addressed word, works out the new value, writes that value back in the next cycle, and returns the old word to the register file, sign-extended to the register width.

The unit also handles the load-reserved / store-conditional pair. A load-reserved records one reservation address. A later store-conditional stores its data only while that reservation covers the same address, and it reports success or failure as the destination value. The core starts an operation with a one-cycle start strobe. It sees busy while the operation runs and a one-cycle done strobe together with the destination write. A misaligned address or an unused function code finishes with a fault indication and touches nothing.

Top module: `amo_unit`

## Requirements
- R1: The function code selects the operation: 00000 add, 00001 swap, 00010 load-reserved, 00011 store-conditional, 00100 xor, 01000 or, 01100 and, 10000 signed min, 10100 signed max, 11000 unsigned min, 11100 unsigned max. Any other code ends with `fault_o`=1, with no memory access and no destination write.
- R2: Load-reserved reads the word, returns it sign-extended (bit 31 copied into all upper bits) and records a reservation for that address. It does not write memory.
- R3: Store-conditional writes the source word only when a valid reservation holds the same address, and then returns 0. Otherwise memory is unchanged and it returns 1.
- R4: Every store-conditional clears the reservation, whether it succeeds or fails. Reset also clears it.
- R5: Swap, add, xor, and, or return the old word sign-extended and store src, old+src, old^src, old&src or old|src to the same address.
- R6: Signed min/max store the smaller or larger of old and src, compared as two's-complement values.
- R7: Unsigned min/max store the smaller or larger of old and src, compared as unsigned values.
- R8: A destination index of 0 suppresses `rd_we_o`, but the memory update still takes place.
- R9: A start taken while idle gives this sequence: one read cycle, then the write cycle immediately after it, then `done_o` high for exactly one cycle. For a read-modify-write, done therefore comes 3 cycles after start. A store-conditional has no read cycle and finishes in 2 cycles. `busy_o` is high from the cycle after start until done.
- R10: An address with bits [1:0] not 00 ends one cycle after start with `fault_o`=1, with no memory request and no destination write.
- R11: A store-conditional to an address other than the reserved one fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (sampled while idle) |
| funct5_i | input | 5 | Operation code |
| addr_i | input | AW | Byte address |
| src_i | input | XLEN | Second source operand |
| rd_i | input | 5 | Destination register index |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| fault_o | output | 1 | Misaligned or unknown operation (valid with done) |
| rd_we_o | output | 1 | Destination write enable |
| rd_idx_o | output | 5 | Destination index |
| rd_data_o | output | XLEN | Destination value |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (with request) |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid the cycle after a read request |

## Verification
The bench targets the boundaries of signed against unsigned comparison, using words with bit 31 set against small positive operands. A design that mixes up the comparison stores the wrong extreme value. It also targets reservation lifetime: a repeated store-conditional, a store-conditional to a neighbouring word, and one issued after a reset must all fail. A design that keeps a stale reservation would corrupt memory and return 0. The bench runs the register width at 64 bits, so a dropped sign extension shows up as a wrong upper half. It also watches the memory port for a misaligned or unknown operation, and for a destination index of 0, where a wrong design either issues an access or loses the memory update.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [4:0] {
    OP_ADD  = 5'b00000,
    OP_SWAP = 5'b00001,
    OP_LDR  = 5'b00010,
    OP_STC  = 5'b00011,
    OP_XOR  = 5'b00100,
    OP_OR   = 5'b01000,
    OP_AND  = 5'b01100,
    OP_MIN  = 5'b10000,
    OP_MAX  = 5'b10100,
    OP_MINU = 5'b11000,
    OP_MAXU = 5'b11100
  } amo_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } amo_st_e;

  function automatic logic op_known(input logic [4:0] code);
    case (code)
      OP_ADD, OP_SWAP, OP_LDR, OP_STC, OP_XOR, OP_OR, OP_AND,
      OP_MIN, OP_MAX, OP_MINU, OP_MAXU: op_known = 1'b1;
      default:                          op_known = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
(
  input  amo_op_e            op_i,
  input  logic [WORD_W-1:0]  old_i,
  input  logic [WORD_W-1:0]  src_i,
  output logic [WORD_W-1:0]  res_o
);
  logic lt_signed;
  logic lt_unsigned;

  always_comb begin
    lt_signed   = $signed(old_i) < $signed(src_i);
    lt_unsigned = old_i < src_i;
    case (op_i)
      OP_ADD:  res_o = old_i + src_i;
      OP_XOR:  res_o = old_i ^ src_i;
      OP_OR:   res_o = old_i | src_i;
      OP_AND:  res_o = old_i & src_i;
      OP_MIN:  res_o = lt_signed   ? old_i : src_i;
      OP_MAX:  res_o = lt_signed   ? src_i : old_i;
      OP_MINU: res_o = lt_unsigned ? old_i : src_i;
      OP_MAXU: res_o = lt_unsigned ? src_i : old_i;
      default: res_o = src_i;
    endcase
  end
endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_i,
  input  logic          clr_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  logic          valid_q, valid_d;
  logic [AW-1:0] addr_q;
  logic          addr_en;

  always_comb begin
    valid_d = valid_q;
    if (set_i) valid_d = 1'b1;
    if (clr_i) valid_d = 1'b0;
    addr_en = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (addr_en) addr_q <= addr_i;
  end

  assign hit_o = valid_q && (addr_q == addr_i);

  a_r4_clear_drops_resv: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !hit_o);
  a_r2_set_holds_resv: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> valid_q);
endmodule

// File: rtl/amo_seq.sv
module amo_seq
  import amo_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned AW   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [4:0]        funct5_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [XLEN-1:0]   src_i,
  input  logic [4:0]        rd_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fault_o,
  output logic              rd_we_o,
  output logic [4:0]        rd_idx_o,
  output logic [XLEN-1:0]   rd_data_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output amo_op_e           alu_op_o,
  output logic [WORD_W-1:0] alu_src_o,
  input  logic [WORD_W-1:0] alu_res_i,
  output logic              rsv_set_o,
  output logic              rsv_clr_o,
  output logic [AW-1:0]     rsv_addr_o,
  input  logic              rsv_hit_i
);
  localparam int unsigned ALIGN_W = 2;

  amo_st_e           st_q, st_d;
  amo_op_e           op_q;
  logic [AW-1:0]     addr_q;
  logic [WORD_W-1:0] src_q;
  logic [4:0]        rd_q;
  logic              fault_q, fault_d;
  logic [XLEN-1:0]   res_q, res_d;
  logic              cap_en, res_en;
  logic              bad_req;

  function automatic logic [XLEN-1:0] sext_word(input logic [WORD_W-1:0] w);
    logic [XLEN-1:0] r;
    r = {XLEN{w[WORD_W-1]}};
    r[WORD_W-1:0] = w;
    return r;
  endfunction

  always_comb begin
    bad_req = !op_known(funct5_i) || (addr_i[ALIGN_W-1:0] != '0);
    cap_en  = (st_q == ST_IDLE) && start_i;
    res_en  = (st_q == ST_WRITE);
    fault_d = bad_req;
    st_d    = st_q;
    case (st_q)
      ST_IDLE:
        if (start_i) begin
          if (bad_req)                           st_d = ST_DONE;
          else if (amo_op_e'(funct5_i) == OP_STC) st_d = ST_WRITE;
          else                                   st_d = ST_READ;
        end
      ST_READ:  st_d = ST_WRITE;
      ST_WRITE: st_d = ST_DONE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_wdata_o = alu_res_i;
    if (st_q == ST_READ) begin
      mem_req_o = 1'b1;
    end else if (st_q == ST_WRITE) begin
      if (op_q == OP_STC) begin
        mem_req_o   = rsv_hit_i;
        mem_we_o    = rsv_hit_i;
        mem_wdata_o = src_q;
      end else if (op_q != OP_LDR) begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
      end
    end
  end

  always_comb begin
    if (op_q == OP_STC) begin
      res_d    = '0;
      res_d[0] = !rsv_hit_i;
    end else begin
      res_d = sext_word(mem_rdata_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      op_q    <= amo_op_e'(funct5_i);
      addr_q  <= addr_i;
      src_q   <= src_i[WORD_W-1:0];
      rd_q    <= rd_i;
      fault_q <= fault_d;
    end
    if (res_en) res_q <= res_d;
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = (st_q == ST_DONE);
  assign fault_o    = done_o && fault_q;
  assign rd_we_o    = done_o && !fault_q && (rd_q != '0);
  assign rd_idx_o   = rd_q;
  assign rd_data_o  = res_q;
  assign mem_addr_o = addr_q;
  assign alu_op_o   = op_q;
  assign alu_src_o  = src_q;
  assign rsv_addr_o = addr_q;
  assign rsv_set_o  = (st_q == ST_WRITE) && (op_q == OP_LDR);
  assign rsv_clr_o  = (st_q == ST_WRITE) && (op_q == OP_STC);

  a_r9_write_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> mem_req_o);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r9_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && op_q != OP_STC) |-> $past(mem_req_o && !mem_we_o));
  a_r8_no_rd_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we_o |-> (rd_idx_o != 5'd0));
  a_r10_fault_no_rd: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> !rd_we_o);
  a_r10_fault_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && start_i && bad_req) |=> (!mem_req_o && done_o));
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned AW   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [4:0]        funct5_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [XLEN-1:0]   src_i,
  input  logic [4:0]        rd_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fault_o,
  output logic              rd_we_o,
  output logic [4:0]        rd_idx_o,
  output logic [XLEN-1:0]   rd_data_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i
);
  amo_op_e           alu_op;
  logic [WORD_W-1:0] alu_src, alu_res;
  logic              rsv_set, rsv_clr, rsv_hit;
  logic [AW-1:0]     rsv_addr;

  amo_seq #(.XLEN(XLEN), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .funct5_i(funct5_i),
    .addr_i(addr_i), .src_i(src_i), .rd_i(rd_i),
    .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o),
    .rd_we_o(rd_we_o), .rd_idx_o(rd_idx_o), .rd_data_o(rd_data_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .alu_op_o(alu_op), .alu_src_o(alu_src), .alu_res_i(alu_res),
    .rsv_set_o(rsv_set), .rsv_clr_o(rsv_clr), .rsv_addr_o(rsv_addr),
    .rsv_hit_i(rsv_hit)
  );

  amo_alu u_alu (
    .op_i(alu_op), .old_i(mem_rdata_i), .src_i(alu_src), .res_o(alu_res)
  );

  amo_resv #(.AW(AW)) u_resv (
    .clk(clk), .rst_n(rst_n), .set_i(rsv_set), .clr_i(rsv_clr),
    .addr_i(rsv_addr), .hit_o(rsv_hit)
  );

  a_r2_no_write_on_lr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_set && mem_req_o) |-> !mem_we_o);
endmodule

// File: tb/test_amo_unit.sv
`timescale 1ns/1ps
module test_amo_unit;
  localparam int XLEN = 64;
  localparam int AW   = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i;
  logic [4:0] funct5_i;
  logic [AW-1:0] addr_i;
  logic [XLEN-1:0] src_i;
  logic [4:0] rd_i;
  logic busy_o, done_o, fault_o, rd_we_o, mem_req_o, mem_we_o;
  logic [4:0] rd_idx_o;
  logic [XLEN-1:0] rd_data_o;
  logic [AW-1:0] mem_addr_o;
  logic [31:0] mem_wdata_o, mem_rdata_i;

  always #2.5 clk = ~clk;

  amo_unit #(.XLEN(XLEN), .AW(AW)) i_amo_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .funct5_i(funct5_i),
    .addr_i(addr_i), .src_i(src_i), .rd_i(rd_i), .busy_o(busy_o),
    .done_o(done_o), .fault_o(fault_o), .rd_we_o(rd_we_o),
    .rd_idx_o(rd_idx_o), .rd_data_o(rd_data_o), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i)
  );

  logic [31:0] mem [64];
  logic [31:0] shadow [64];
  logic        sh_resv;
  logic [AW-1:0] sh_raddr;

  always @(posedge clk) begin
    if (mem_req_o) begin
      if (mem_we_o) mem[mem_addr_o[7:2]] <= mem_wdata_o;
      else          mem_rdata_i <= mem[mem_addr_o[7:2]];
    end
  end

  typedef struct {
    logic fault;
    logic we;
    logic [4:0] idx;
    logic [XLEN-1:0] data;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  int n_vec = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] expv);
    n_vec++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  function automatic logic [XLEN-1:0] sx(input logic [31:0] w);
    return {{(XLEN-32){w[31]}}, w};
  endfunction

  // monitor: compares completions against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (exp_q.size() == 0) begin
        chk("R9 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " fault"}, XLEN'(fault_o), XLEN'(e.fault));
        chk({e.tag, " rd_we"}, XLEN'(rd_we_o), XLEN'(e.we));
        if (e.we) begin
          chk({e.tag, " rd_idx"}, XLEN'(rd_idx_o), XLEN'(e.idx));
          chk({e.tag, " rd_data"}, rd_data_o, e.data);
        end
      end
    end
  end

  task automatic run_op(input string tag, input logic [4:0] f5, input logic [AW-1:0] a,
                        input logic [31:0] s, input logic [4:0] rd);
    exp_t e;
    int wi, lat, exp_lat, nrd, nwr, exp_rd, exp_wr;
    logic known, hit;
    logic [31:0] old, nw;
    wi = int'(a[7:2]);
    known = (f5 inside {5'b00000, 5'b00001, 5'b00010, 5'b00011, 5'b00100, 5'b01000,
                        5'b01100, 5'b10000, 5'b10100, 5'b11000, 5'b11100});
    e.tag = tag; e.idx = rd; e.fault = 0; e.we = (rd != 0); e.data = '0;
    exp_rd = 0; exp_wr = 0;
    if (!known || a[1:0] != 2'b00) begin
      e.fault = 1; e.we = 0; exp_lat = 1;
    end else if (f5 == 5'b00011) begin
      hit = sh_resv && (sh_raddr == a);
      if (hit) shadow[wi] = s;
      e.data = hit ? '0 : XLEN'(1);
      sh_resv = 0; exp_lat = 2; exp_wr = hit ? 1 : 0;
    end else begin
      old = shadow[wi];
      e.data = sx(old); exp_lat = 3; exp_rd = 1;
      if (f5 == 5'b00010) begin
        sh_resv = 1; sh_raddr = a;
      end else begin
        case (f5)
          5'b00001: nw = s;
          5'b00000: nw = old + s;
          5'b00100: nw = old ^ s;
          5'b01100: nw = old & s;
          5'b01000: nw = old | s;
          5'b10000: nw = ($signed(old) > $signed(s)) ? s : old;
          5'b10100: nw = ($signed(old) < $signed(s)) ? s : old;
          5'b11000: nw = (old > s) ? s : old;
          default:  nw = (old < s) ? s : old;
        endcase
        shadow[wi] = nw; exp_wr = 1;
      end
    end
    exp_q.push_back(e);
    funct5_i = f5; addr_i = a; src_i = {32'hDEAD_BEEF, s}; rd_i = rd; start_i = 1;
    lat = 0; nrd = 0; nwr = 0;
    while (lat < 20) begin
      @(negedge clk);
      start_i = 0;
      lat++;
      if (done_o) break;
      if (mem_req_o && !mem_we_o) nrd++;
      if (mem_req_o && mem_we_o)  nwr++;
    end
    chk({tag, " R9 latency"}, XLEN'(lat), XLEN'(exp_lat));
    chk({tag, " R9 reads"}, XLEN'(nrd), XLEN'(exp_rd));
    chk({tag, " R10 writes"}, XLEN'(nwr), XLEN'(exp_wr));
    chk({tag, " memory word"}, XLEN'(mem[wi]), XLEN'(shadow[wi]));
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; start_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    sh_resv = 0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    funct5_i = 0; addr_i = 0; src_i = 0; rd_i = 0; start_i = 0;
    mem_rdata_i = 0;
    for (int i = 0; i < 64; i++) begin
      mem[i] = 32'h1357_9BDF * i + 32'h8000_0001;
      shadow[i] = mem[i];
    end
    mem[16] = 32'hFFFF_FFF0; shadow[16] = 32'hFFFF_FFF0;
    mem[17] = 32'h0000_0010; shadow[17] = 32'h0000_0010;
    do_reset();
    // reset state
    chk("R9 reset busy", XLEN'(busy_o), 0);
    chk("R9 reset done", XLEN'(done_o), 0);
    chk("R9 reset mem_req", XLEN'(mem_req_o), 0);

    run_op("R2 lr", 5'b00010, 8'h10, 32'h0, 5'd5);
    run_op("R3 sc success", 5'b00011, 8'h10, 32'h1234_5678, 5'd6);
    run_op("R4 sc after sc fails", 5'b00011, 8'h10, 32'hAAAA_0000, 5'd6);
    run_op("R2 lr other", 5'b00010, 8'h20, 32'h0, 5'd7);
    run_op("R11 sc wrong addr", 5'b00011, 8'h24, 32'h5555_5555, 5'd7);
    run_op("R4 sc after failed sc", 5'b00011, 8'h20, 32'h5555_5555, 5'd7);
    run_op("R5 swap", 5'b00001, 8'h30, 32'hCAFE_F00D, 5'd8);
    run_op("R5 add", 5'b00000, 8'h30, 32'h0000_0003, 5'd9);
    run_op("R5 add wrap", 5'b00000, 8'h34, 32'hFFFF_FFFF, 5'd9);
    run_op("R5 xor", 5'b00100, 8'h38, 32'h0F0F_0F0F, 5'd10);
    run_op("R5 and", 5'b01100, 8'h38, 32'hFF00_FF00, 5'd11);
    run_op("R5 or", 5'b01000, 8'h3C, 32'h0000_00F1, 5'd12);
    run_op("R6 min neg kept", 5'b10000, 8'h40, 32'h0000_0005, 5'd13);
    run_op("R6 max pos wins", 5'b10100, 8'h40, 32'h0000_0005, 5'd13);
    run_op("R6 min neg src", 5'b10000, 8'h44, 32'h8000_0000, 5'd14);
    run_op("R7 maxu high bit", 5'b11100, 8'h44, 32'h0000_0007, 5'd15);
    run_op("R7 minu small", 5'b11000, 8'h48, 32'h0000_0002, 5'd16);
    run_op("R7 maxu vs ffff", 5'b11100, 8'h48, 32'hFFFF_FFFE, 5'd16);
    run_op("R8 add rd0", 5'b00000, 8'h4C, 32'h0000_0100, 5'd0);
    run_op("R8 lr rd0", 5'b00010, 8'h50, 32'h0, 5'd0);
    run_op("R8 sc rd0 success", 5'b00011, 8'h50, 32'h0BAD_CAFE, 5'd0);
    run_op("R10 misaligned add", 5'b00000, 8'h53, 32'h1, 5'd3);
    run_op("R10 misaligned swap", 5'b00001, 8'h56, 32'h1, 5'd3);
    run_op("R1 unknown code", 5'b00101, 8'h58, 32'h1, 5'd4);
    run_op("R1 unknown code 2", 5'b11111, 8'h58, 32'h1, 5'd4);
    run_op("R2 lr before reset", 5'b00010, 8'h60, 32'h0, 5'd2);
    do_reset();
    run_op("R4 sc after reset fails", 5'b00011, 8'h60, 32'h7777_7777, 5'd2);
    repeat (2) @(negedge clk);
    chk("R9 queue drained", XLEN'(exp_q.size()), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule